// File: doc/BRIEF.md
# Frequency Counter Gate Sequencer

This block produces the timing that a frequency counter needs around its pulse-counting stage. A reference tick arriving at 1 MHz is divided down to a 1 kHz timebase. The block then alternates between two phases. In the open phase, a measurement window of 10, 100, 1000 or 10000 ms is held open. In the closed phase, which lasts about 90 ms, the downstream counter is left alone while its result is taken. Raw input pulses are qualified by the open window and passed on as a count enable.

The closed phase is divided into 10 ms steps. On entry to step 1, a one-cycle update strobe tells the result register to capture the finished count. On entry to step 2, a one-cycle clear strobe zeroes the pulse counter. On entry to step 9, the window reopens using the selection that is present at that moment. Because of this structure the result can change at most ten times per second, however short the window is. All intervals are counted in reference ticks, so `ref_tick` acts as the time base and cycles in which it is low do not advance the sequence.

Top module: `fcg_sequencer`

## Requirements
- R1: A timebase tick occurs once every PRESCALE reference ticks (default 1000). Clock cycles with `ref_tick` low advance no interval of the block.
- R2: The window stays open for GATE_UNIT·10^s timebase ticks, where s is the 2-bit value of `gate_sel`: 0 gives 10 ms, 1 gives 100 ms, 2 gives 1000 ms and 3 gives 10000 ms at the default parameters.
- R3: `gate_sel` is sampled only on the clock edge that reopens the window. A change made while the window is open, or earlier in the closed phase, affects only the next window to open.
- R4: `count_en` is high exactly in the cycles where `in_pulse` is high and `gate_open` is high.
- R5: `upd_stb` is high for one clock cycle, which follows the edge that completes DEAD_UNIT timebase ticks after the window closed.
- R6: `clr_stb` is high for one clock cycle, which follows the edge that completes 2·DEAD_UNIT timebase ticks after the window closed. It therefore always comes after `upd_stb` and never in the same cycle.
- R7: The window reopens on the edge that completes 9·DEAD_UNIT timebase ticks of closed phase. Every window then runs its full length from zero.
- R8: During reset and right after it, all outputs are low and the block is in the closed phase at step zero. The first update strobe, clear strobe and opening follow the R5, R6 and R7 timings counted from the last reset edge.
- R9: Neither strobe is ever high while `gate_open` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ref_tick | input | 1 | One-cycle enable at the reference rate (1 MHz) |
| gate_sel | input | 2 | Window length select: 0 = 10 ms, 1 = 100 ms, 2 = 1 s, 3 = 10 s |
| in_pulse | input | 1 | Conditioned input pulse, one cycle per event |
| count_en | output | 1 | Input pulse qualified by the open window |
| upd_stb | output | 1 | One-cycle request to capture the count |
| clr_stb | output | 1 | One-cycle request to zero the count |
| gate_open | output | 1 | High while the measurement window is open |

## Verification
Two functions can fall in the same cycle: the re-arm edge that samples `gate_sel`, and a change of `gate_sel` by the user. A second such pair is the window-closing edge and an input pulse that has to be cut off by it. To provoke both, the bench drives `in_pulse` and `ref_tick` randomly on every cycle, and in several rounds it changes `gate_sel` on every cycle of the closed phase. In each cycle a reference model predicts the window length from the selection value that was present at the opening edge, and checks that `count_en` falls on the exact closing cycle.

// File: rtl/fcg_pkg.sv
// Shared types and helpers for the gate sequencer.
// Assumes the window select is 2 bits wide and that each code is ten times the previous one.
package fcg_pkg;

    typedef enum logic {
        PH_DEAD = 1'b0,
        PH_OPEN = 1'b1
    } phase_e;

    // Window length in timebase ticks for select code sel.
    function automatic int unsigned gate_ticks(input logic [1:0] sel, input int unsigned unit);
        int unsigned n;
        n = unit;
        for (int i = 0; i < 3; i++) begin
            if (i < int'(sel)) n = n * 10;
        end
        return n;
    endfunction

endpackage

// File: rtl/fcg_prescale.sv
// Divides the reference tick by DIV and gives a one-cycle timebase tick.
// Assumes ref_tick is a single-cycle enable. The chain runs freely, as a divider from an oscillator would.
module fcg_prescale #(
    parameter int unsigned DIV = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_tick,
    output logic tb_tick
);
    localparam int unsigned W = (DIV > 1) ? $clog2(DIV) : 1;

    logic [W-1:0] cnt_q;
    logic         wrap;

    assign wrap    = (cnt_q == W'(DIV - 1));
    assign tb_tick = ref_tick && wrap;

    // Count reference ticks modulo DIV.
    always_ff @(posedge clk) begin
        if (!rst_n)        cnt_q <= '0;
        else if (ref_tick) cnt_q <= wrap ? '0 : cnt_q + 1'b1;
    end
endmodule

// File: rtl/fcg_gate_timer.sv
// Counts timebase ticks while the window is open and flags the tick that ends it.
// Assumes run falls on the cycle after expire. The counter is held at zero whenever run is low.
module fcg_gate_timer
    import fcg_pkg::*;
#(
    parameter int unsigned UNIT = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       tb_tick,
    input  logic [1:0] len_sel,
    output logic       expire
);
    localparam int unsigned MAXLEN = UNIT * 1000;
    localparam int unsigned W      = $clog2(MAXLEN + 1);

    logic [W-1:0] cnt_q;
    logic [W-1:0] last;

    assign last   = W'(gate_ticks(len_sel, UNIT) - 1);
    assign expire = run && tb_tick && (cnt_q == last);

    // Advance on timebase ticks and clear while idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt_q <= '0;
        else if (tb_tick)   cnt_q <= expire ? '0 : cnt_q + 1'b1;
    end
endmodule

// File: rtl/fcg_dead_timer.sv
// Closed-phase timer. A sub-counter of UNIT timebase ticks drives a step counter.
// adv marks the tick that finishes a step, and step gives the value before that edge.
// Assumes the owner stops run before step would pass STEPS-1.
module fcg_dead_timer #(
    parameter int unsigned UNIT   = 10,
    parameter int unsigned STEPS  = 10,
    parameter int unsigned STEP_W = $clog2(STEPS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              tb_tick,
    output logic              adv,
    output logic [STEP_W-1:0] step
);
    localparam int unsigned SUB_W = (UNIT > 1) ? $clog2(UNIT) : 1;

    logic [SUB_W-1:0]  sub_q;
    logic [STEP_W-1:0] step_q;

    assign adv  = run && tb_tick && (sub_q == SUB_W'(UNIT - 1));
    assign step = step_q;

    // Two-level count that is held at zero outside the closed phase.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            sub_q  <= '0;
            step_q <= '0;
        end else if (tb_tick) begin
            sub_q <= adv ? '0 : sub_q + 1'b1;
            if (adv) step_q <= step_q + 1'b1;
        end
    end
endmodule

// File: rtl/fcg_sequencer.sv
// Top of the gate sequencer. It holds the open/closed phase, latches the window
// select at reopening, and decodes the update, clear and re-arm steps of the closed phase.
// Assumes UPD_STEP < CLR_STEP < REARM_STEP and that every input is synchronous to clk.
module fcg_sequencer
    import fcg_pkg::*;
#(
    parameter int unsigned PRESCALE   = 1000,
    parameter int unsigned GATE_UNIT  = 10,
    parameter int unsigned DEAD_UNIT  = 10,
    parameter int unsigned UPD_STEP   = 1,
    parameter int unsigned CLR_STEP   = 2,
    parameter int unsigned REARM_STEP = 9
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ref_tick,
    input  logic [1:0] gate_sel,
    input  logic       in_pulse,
    output logic       count_en,
    output logic       upd_stb,
    output logic       clr_stb,
    output logic       gate_open
);
    localparam int unsigned STEP_W = $clog2(REARM_STEP + 1);

    phase_e            phase_q;
    logic [1:0]        sel_q;
    logic              tb_tick;
    logic              expire;
    logic              adv;
    logic [STEP_W-1:0] step;
    logic              hit_upd, hit_clr, hit_rearm;
    logic              upd_q, clr_q;

    fcg_prescale #(.DIV(PRESCALE)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .ref_tick(ref_tick),
        .tb_tick (tb_tick)
    );

    fcg_gate_timer #(.UNIT(GATE_UNIT)) u_gate (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (phase_q == PH_OPEN),
        .tb_tick(tb_tick),
        .len_sel(sel_q),
        .expire (expire)
    );

    fcg_dead_timer #(
        .UNIT  (DEAD_UNIT),
        .STEPS (REARM_STEP + 1),
        .STEP_W(STEP_W)
    ) u_dead (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (phase_q == PH_DEAD),
        .tb_tick(tb_tick),
        .adv    (adv),
        .step   (step)
    );

    assign hit_upd   = adv && (step == STEP_W'(UPD_STEP - 1));
    assign hit_clr   = adv && (step == STEP_W'(CLR_STEP - 1));
    assign hit_rearm = adv && (step == STEP_W'(REARM_STEP - 1));

    // Phase flip-flop: it is cleared by the window expiry and set again by the re-arm step.
    always_ff @(posedge clk) begin
        if (!rst_n)                                   phase_q <= PH_DEAD;
        else if (phase_q == PH_OPEN && expire)        phase_q <= PH_DEAD;
        else if (phase_q == PH_DEAD && hit_rearm)     phase_q <= PH_OPEN;
    end

    // Capture the window select at the moment the window reopens.
    always_ff @(posedge clk) begin
        if (!rst_n)                                   sel_q <= 2'b00;
        else if (phase_q == PH_DEAD && hit_rearm)     sel_q <= gate_sel;
    end

    // One-cycle strobes raised on entry to their step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upd_q <= 1'b0;
            clr_q <= 1'b0;
        end else begin
            upd_q <= hit_upd;
            clr_q <= hit_clr;
        end
    end

    assign gate_open = (phase_q == PH_OPEN);
    assign count_en  = in_pulse && gate_open;
    assign upd_stb   = upd_q;
    assign clr_stb   = clr_q;
endmodule

// File: rtl/fcg_sequencer_chk.sv
// Temporal checks on the sequencer ports. It is attached to every instance through bind.
module fcg_sequencer_chk (
    input logic clk,
    input logic rst_n,
    input logic ref_tick,
    input logic in_pulse,
    input logic count_en,
    input logic upd_stb,
    input logic clr_stb,
    input logic gate_open
);
    // R6
    strobe_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(upd_stb && clr_stb));

    // R5
    upd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_stb |=> !upd_stb);

    // R6
    clr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_stb |=> !clr_stb);

    // R9
    strobe_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_stb || clr_stb) |-> !gate_open);

    // R1
    open_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_open) |-> $past(ref_tick));

    // R1
    close_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(gate_open) |-> $past(ref_tick));

    // R7
    no_strobe_at_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_open) |-> !$past(upd_stb) && !$past(clr_stb));
endmodule

bind fcg_sequencer fcg_sequencer_chk u_fcg_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ref_tick (ref_tick),
    .in_pulse (in_pulse),
    .count_en (count_en),
    .upd_stb  (upd_stb),
    .clr_stb  (clr_stb),
    .gate_open(gate_open)
);

// File: tb/fcg_sequencer_bench.sv
// Bench for the gate sequencer, built with a reduced timebase. A reference model counts
// reference ticks since the last anchor edge and predicts every output in every cycle.
module fcg_sequencer_bench;
    localparam int unsigned P  = 2;   // PRESCALE
    localparam int unsigned GU = 2;   // GATE_UNIT
    localparam int unsigned DU = 2;   // DEAD_UNIT
    localparam int unsigned DP = DU * P;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_tick = 1'b0;
    logic [1:0] gate_sel = 2'b00;
    logic       in_pulse = 1'b0;
    logic       count_en, upd_stb, clr_stb, gate_open;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  jitter = 1'b0;
    bit  done = 1'b0;

    always #10 clk = ~clk;

    fcg_sequencer #(
        .PRESCALE (P),
        .GATE_UNIT(GU),
        .DEAD_UNIT(DU)
    ) u_fcg_sequencer (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_tick (ref_tick),
        .gate_sel (gate_sel),
        .in_pulse (in_pulse),
        .count_en (count_en),
        .upd_stb  (upd_stb),
        .clr_stb  (clr_stb),
        .gate_open(gate_open)
    );

    // Window length in reference ticks for a select code (R2).
    function automatic int win_ref(input logic [1:0] s);
        int n;
        n = GU * P;
        for (int i = 0; i < 3; i++) if (i < int'(s)) n = n * 10;
        return n;
    endfunction

    task automatic cmp(input string tag, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model that is sampled at the negedge.
    bit         prev_rst = 1'b0, prev_ref = 1'b0;
    logic [1:0] sel_prev = 2'b00, exp_sel = 2'b00;
    bit         exp_open = 1'b0;
    int         since = 0;

    always @(negedge clk) begin
        logic e_upd, e_clr;
        string gtag;
        if (!prev_rst) begin
            since    = 0;              // R8: closed phase at step zero
            exp_open = 1'b0;
        end else begin
            if (prev_ref) since++;     // R1: only enabled reference ticks advance time
            if (!exp_open && since == 9 * DP) begin
                exp_open = 1'b1;       // R7 reopen, R3 select latched at that edge
                exp_sel  = sel_prev;
                since    = 0;
            end else if (exp_open && since == win_ref(exp_sel)) begin
                exp_open = 1'b0;       // R2 window end
                since    = 0;
            end
        end
        e_upd = prev_rst && prev_ref && !exp_open && since == DP;
        e_clr = prev_rst && prev_ref && !exp_open && since == 2 * DP;
        if (!done) begin
            if (!prev_rst) gtag = "R8 gate_open";
            else if (exp_open) gtag = "R2 R3 R1 gate_open";
            else gtag = "R7 R1 gate_open";
            cmp(gtag, gate_open, exp_open);
            cmp(prev_rst ? "R5 R9 upd_stb" : "R8 upd_stb", upd_stb, e_upd);
            cmp(prev_rst ? "R6 R9 clr_stb" : "R8 clr_stb", clr_stb, e_clr);
            cmp(prev_rst ? "R4 count_en" : "R8 count_en", count_en, in_pulse & exp_open);
        end
        sel_prev = gate_sel;
        prev_ref = ref_tick;
        prev_rst = rst_n;
    end

    task automatic wait_rise();
        @(negedge clk);
        while (!gate_open) @(negedge clk);
    endtask

    task automatic wait_fall();
        @(negedge clk);
        while (gate_open) @(negedge clk);
    endtask

    task automatic summary();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        fork
            // Random reference ticks and pulses. While jitter is set, the select also changes on every closed-phase cycle.
            forever begin
                @(posedge clk);
                #2;
                ref_tick = ($urandom_range(3) != 0);
                in_pulse = $urandom_range(1) != 0;
                if (jitter && !gate_open) gate_sel = 2'($urandom_range(1));
            end
            begin
                repeat (3) @(posedge clk);
                #2 rst_n = 1'b1;
                // R2/R3 sweep: the select is changed mid-window and applies to the next window.
                for (int s = 1; s <= 4; s++) begin
                    wait_rise();
                    @(posedge clk);
                    #3 gate_sel = 2'(s % 4);
                    wait_fall();
                end
                // R8: reset in the middle of a window.
                wait_rise();
                repeat (2) @(posedge clk);
                #3 rst_n = 1'b0;
                repeat (3) @(posedge clk);
                #3 rst_n = 1'b1;
                // R3: the select moves on every cycle around the re-arm edge.
                jitter = 1'b1;
                for (int k = 0; k < 6; k++) begin
                    wait_rise();
                    wait_fall();
                end
                jitter = 1'b0;
                repeat (50) @(posedge clk);
                summary();
            end
        join_any
    end
endmodule